// File: doc/BRIEF.md
# Checksummed Serial Frame Link

This block sits between a full-duplex byte link and the logic that handles messages. Its receive side watches the incoming byte stream for a start byte. It then reads a header that carries a transaction ID, a payload length and a message type, followed by a header check byte. The payload bytes pass straight through to a payload stream as they arrive. A trailing check byte closes the frame, and a one-cycle `frm_ok` pulse is raised only after that byte has matched. A frame that fails any check produces a one-cycle `frm_err` pulse instead, and the parser goes back to searching. A sender that stalls too long inside a frame causes the parser to abandon the frame without an error pulse.

The transmit side accepts a request that gives a type, a length and either "new transaction" or "reply to ID". It emits the header, forwards the payload bytes it is fed, and appends the check byte. A new transaction receives a fresh ID whose top bit identifies this peer and whose lower 15 bits come from a counter. A reply reuses the ID it is given.

All byte paths are valid/ready streams. A byte moves only on a clock edge where both valid and ready are high. A source holds its byte and its valid until the transfer happens. During the payload phase, receive back-pressure is passed through: `rx_ready` follows `pay_ready`. Outside the payload phase `rx_ready` is high. On transmit, `txp_ready` is high only while the payload is being sent and `out_ready` accepts the byte.

Top module: `frame_link`

## Requirements
- R1: While searching, the receiver drops every byte other than 0x01. A byte of value 0x01 starts a frame.
- R2: The header bytes are, in order: 0x01, ID high, ID low, length high, length low, type, header check. `frm_id`, `frm_len` and `frm_type` hold the values of the last received frame when `frm_ok` pulses.
- R3: The header check byte is the bitwise inverse of the XOR of the six bytes before it. If it does not match, `frm_err` pulses for one cycle, `frm_ok` stays low and the receiver returns to searching.
- R4: Payload bytes come out on `pay_data` in order, one per transfer. `rx_ready` follows `pay_ready` during the payload phase.
- R5: If the length is non-zero, a payload check byte follows the payload. Its value is the inverse of the XOR of the payload bytes. `frm_ok` pulses the cycle after that byte is accepted, and only if it matches; otherwise `frm_err` pulses. If the length is zero, there is no payload check byte and `frm_ok` pulses the cycle after the header check byte.
- R6: A length above `MAX_LEN` with a correct header check is rejected with a `frm_err` pulse, and the receiver returns to searching.
- R7: Inside a frame, `gap_limit + 1` consecutive cycles without `rx_valid` send the receiver back to searching with no pulse. Gaps of `gap_limit` cycles or fewer are tolerated. `gap_limit = 0` disables the timeout.
- R8: The transmitter sends the same byte format with both check bytes computed as in R3 and R5. It sends no payload check byte when the length is zero.
- R9: A new-transaction request is given the ID `{PEER_BIT, seq}`. `seq` is 0 after reset and advances by one for each new transaction.
- R10: A reply request sends `req_id` unchanged and leaves `seq` untouched.
- R11: `frm_ok` and `frm_err` never pulse in the same cycle. Each pulses only in the cycle right after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_limit | input | GAP_W | Idle cycles tolerated inside a received frame (0 = no timeout) |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte accepted |
| rx_data | input | 8 | Incoming byte |
| pay_valid | output | 1 | Received payload byte valid |
| pay_ready | input | 1 | Payload sink ready |
| pay_data | output | 8 | Received payload byte |
| frm_ok | output | 1 | One-cycle pulse: frame fully verified |
| frm_err | output | 1 | One-cycle pulse: frame rejected |
| frm_id | output | 16 | Received transaction ID |
| frm_len | output | 16 | Received payload length |
| frm_type | output | 8 | Received message type |
| req_valid | input | 1 | Transmit request valid |
| req_ready | output | 1 | Transmitter idle, request taken |
| req_type | input | 8 | Type of the frame to send |
| req_len | input | 16 | Payload length of the frame to send |
| req_reply | input | 1 | 1 = reuse `req_id`, 0 = allocate a new ID |
| req_id | input | 16 | ID used when replying |
| tx_id | output | 16 | ID given to the last accepted request |
| txp_valid | input | 1 | Transmit payload byte valid |
| txp_ready | output | 1 | Transmit payload byte taken |
| txp_data | input | 8 | Transmit payload byte |
| out_valid | output | 1 | Outgoing byte valid |
| out_ready | input | 1 | Link ready for outgoing byte |
| out_data | output | 8 | Outgoing byte |

## Verification
The bench injects corrupted header check bytes, corrupted payload check bytes and lengths one above the limit. A parser that checks only the payload, or only the header, would report such a frame as good. The bench sends junk before the start byte. A hunter that latched on too early would misread the whole header. It also pauses exactly `gap_limit` and `gap_limit + 1` cycles mid-frame and then sends a clean frame. An off-by-one timer would either drop a good frame or swallow the next start byte as header data. On transmit it checks zero-length frames for a missing check byte, and it checks that replies do not advance the ID counter. A design that got either wrong would shift every later ID.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;
  localparam logic [7:0] SOF_BYTE = 8'h01;

  typedef enum logic [3:0] {
    RX_HUNT, RX_IDH, RX_IDL, RX_LENH, RX_LENL, RX_TYPE, RX_HCK, RX_PAY, RX_PCK
  } rx_st_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_HDR, TX_PAY, TX_PCK
  } tx_st_e;
endpackage

// File: rtl/frame_gap_timer.sv
module frame_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             seen,
  input  logic [GAP_W-1:0] limit,
  output logic             expire
);
  logic [GAP_W-1:0] idle_cnt;

  assign expire = active && !seen && (limit != '0) && (idle_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!active || seen || limit == '0 || expire) idle_cnt <= '0;
    else idle_cnt <= idle_cnt + 1'b1;
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_link_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        pay_valid,
  input  logic        pay_ready,
  output logic [7:0]  pay_data,
  output logic        ok,
  output logic        err,
  output logic [15:0] f_id,
  output logic [15:0] f_len,
  output logic [7:0]  f_type,
  output logic        hunting
);
  localparam logic [15:0] LEN_LIMIT = 16'(MAX_LEN);

  rx_st_e      st;
  logic [7:0]  acc;
  logic [15:0] cnt;
  logic        take;

  assign in_ready  = (st == RX_PAY) ? pay_ready : 1'b1;
  assign pay_valid = (st == RX_PAY) && in_valid;
  assign pay_data  = in_data;
  assign take      = in_valid && in_ready;
  assign hunting   = (st == RX_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_HUNT;
      acc <= '0;
      cnt <= '0;
      ok <= 1'b0;
      err <= 1'b0;
      f_id <= '0;
      f_len <= '0;
      f_type <= '0;
    end else begin
      ok <= 1'b0;
      err <= 1'b0;
      if (abort) begin
        st <= RX_HUNT;
      end else if (take) begin
        case (st)
          RX_HUNT: if (in_data == SOF_BYTE) begin
            acc <= SOF_BYTE;
            st <= RX_IDH;
          end
          RX_IDH: begin f_id[15:8] <= in_data; acc <= acc ^ in_data; st <= RX_IDL; end
          RX_IDL: begin f_id[7:0] <= in_data; acc <= acc ^ in_data; st <= RX_LENH; end
          RX_LENH: begin f_len[15:8] <= in_data; acc <= acc ^ in_data; st <= RX_LENL; end
          RX_LENL: begin f_len[7:0] <= in_data; acc <= acc ^ in_data; st <= RX_TYPE; end
          RX_TYPE: begin f_type <= in_data; acc <= acc ^ in_data; st <= RX_HCK; end
          RX_HCK: begin
            if (in_data == ~acc && f_len <= LEN_LIMIT) begin
              if (f_len == '0) begin
                ok <= 1'b1;
                st <= RX_HUNT;
              end else begin
                acc <= '0;
                cnt <= '0;
                st <= RX_PAY;
              end
            end else begin
              err <= 1'b1;
              st <= RX_HUNT;
            end
          end
          RX_PAY: begin
            acc <= acc ^ in_data;
            cnt <= cnt + 16'd1;
            if (cnt == f_len - 16'd1) st <= RX_PCK;
          end
          RX_PCK: begin
            if (in_data == ~acc) ok <= 1'b1;
            else err <= 1'b1;
            st <= RX_HUNT;
          end
          default: st <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_link_pkg::*;
#(
  parameter logic PEER_BIT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_type,
  input  logic [15:0] req_len,
  input  logic        req_reply,
  input  logic [15:0] req_id,
  output logic [15:0] tx_id,
  input  logic        txp_valid,
  output logic        txp_ready,
  input  logic [7:0]  txp_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);
  tx_st_e      st;
  logic [2:0]  idx;
  logic [7:0]  acc;
  logic [7:0]  typ;
  logic [7:0]  hdr_byte;
  logic [15:0] len;
  logic [15:0] cnt;
  logic [14:0] seq;
  logic        fire;

  always_comb begin
    case (idx)
      3'd0: hdr_byte = SOF_BYTE;
      3'd1: hdr_byte = tx_id[15:8];
      3'd2: hdr_byte = tx_id[7:0];
      3'd3: hdr_byte = len[15:8];
      3'd4: hdr_byte = len[7:0];
      3'd5: hdr_byte = typ;
      default: hdr_byte = ~acc;
    endcase
  end

  assign req_ready = (st == TX_IDLE);
  assign txp_ready = (st == TX_PAY) && out_ready;
  assign out_valid = (st == TX_HDR) || (st == TX_PCK) || ((st == TX_PAY) && txp_valid);
  assign out_data  = (st == TX_PAY) ? txp_data : (st == TX_PCK) ? ~acc : hdr_byte;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE;
      idx <= '0;
      acc <= '0;
      typ <= '0;
      len <= '0;
      cnt <= '0;
      seq <= '0;
      tx_id <= '0;
    end else begin
      case (st)
        TX_IDLE: if (req_valid) begin
          len <= req_len;
          typ <= req_type;
          idx <= '0;
          acc <= '0;
          if (req_reply) tx_id <= req_id;
          else begin
            tx_id <= {PEER_BIT, seq};
            seq <= seq + 15'd1;
          end
          st <= TX_HDR;
        end
        TX_HDR: if (fire) begin
          idx <= idx + 3'd1;
          if (idx == 3'd6) begin
            acc <= '0;
            cnt <= '0;
            st <= (len == '0) ? TX_IDLE : TX_PAY;
          end else begin
            acc <= acc ^ out_data;
          end
        end
        TX_PAY: if (fire) begin
          acc <= acc ^ out_data;
          cnt <= cnt + 16'd1;
          if (cnt == len - 16'd1) st <= TX_PCK;
        end
        TX_PCK: if (fire) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_link.sv
module frame_link #(
  parameter int   MAX_LEN  = 64,
  parameter int   GAP_W    = 16,
  parameter logic PEER_BIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             pay_valid,
  input  logic             pay_ready,
  output logic [7:0]       pay_data,
  output logic             frm_ok,
  output logic             frm_err,
  output logic [15:0]      frm_id,
  output logic [15:0]      frm_len,
  output logic [7:0]       frm_type,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_type,
  input  logic [15:0]      req_len,
  input  logic             req_reply,
  input  logic [15:0]      req_id,
  output logic [15:0]      tx_id,
  input  logic             txp_valid,
  output logic             txp_ready,
  input  logic [7:0]       txp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  logic hunting;
  logic gap_abort;

  frame_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .active(!hunting), .seen(rx_valid),
    .limit(gap_limit), .expire(gap_abort)
  );

  frame_rx #(.MAX_LEN(MAX_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort(gap_abort),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .ok(frm_ok), .err(frm_err), .f_id(frm_id), .f_len(frm_len),
    .f_type(frm_type), .hunting(hunting)
  );

  frame_tx #(.PEER_BIT(PEER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_len(req_len), .req_reply(req_reply), .req_id(req_id), .tx_id(tx_id),
    .txp_valid(txp_valid), .txp_ready(txp_ready), .txp_data(txp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/frame_link_chk.sv
module frame_link_chk #(
  parameter logic PEER_BIT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        frm_ok,
  input logic        frm_err,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_reply,
  input logic [15:0] req_id,
  input logic [15:0] tx_id,
  input logic        out_valid,
  input logic [7:0]  out_data
);
  a_r11_ok_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_ok && frm_err));

  a_r5_ok_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ok |-> $past(rx_valid && rx_ready));

  a_r3_err_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> $past(rx_valid && rx_ready));

  a_r9_new_id_top: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_reply) |=> (tx_id[15] == PEER_BIT));

  a_r10_reply_id: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_reply) |=> (tx_id == $past(req_id)));

  a_r8_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && out_data == 8'h01));
endmodule

bind frame_link frame_link_chk #(.PEER_BIT(PEER_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .frm_ok(frm_ok), .frm_err(frm_err), .req_valid(req_valid),
  .req_ready(req_ready), .req_reply(req_reply), .req_id(req_id),
  .tx_id(tx_id), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_frame_link.sv
`timescale 1ns/1ps
module sim_frame_link;
  localparam int   MAXL = 64;
  localparam logic PEER = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] gap_limit = 16'd5;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic pay_valid, pay_ready = 1'b1;
  logic [7:0] pay_data;
  logic frm_ok, frm_err;
  logic [15:0] frm_id, frm_len;
  logic [7:0] frm_type;
  logic req_valid = 1'b0, req_ready, req_reply = 1'b0;
  logic [7:0] req_type = '0;
  logic [15:0] req_len = '0, req_id = '0, tx_id;
  logic txp_valid = 1'b0, txp_ready;
  logic [7:0] txp_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;

  frame_link #(.MAX_LEN(MAXL), .GAP_W(16), .PEER_BIT(PEER)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ok_cnt = 0, err_cnt = 0, ok0 = 0, err0 = 0;
  bit rnd_bp = 1'b0;
  logic [7:0] pl [0:MAXL];
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [14:0] seq_m = '0;

  always @(posedge clk) begin
    #1;
    pay_ready = rnd_bp ? ($urandom % 4 != 0) : 1'b1;
    out_ready = rnd_bp ? ($urandom % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pay_valid && pay_ready) rxq.push_back(pay_data);
      if (out_valid && out_ready) txq.push_back(out_data);
      if (frm_ok) ok_cnt++;
      if (frm_err) err_cnt++;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung (act=%0d cycles, exp<150000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit c, input string tag, input longint act, input longint exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hsum(input logic [15:0] id, input logic [15:0] len, input logic [7:0] t);
    return ~(8'h01 ^ id[15:8] ^ id[7:0] ^ len[15:8] ^ len[7:0] ^ t);
  endfunction

  function automatic logic [7:0] psum(input int len);
    logic [7:0] a = '0;
    for (int i = 0; i < len; i++) a ^= pl[i];
    return ~a;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rx_put(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic mark();
    ok0 = ok_cnt; err0 = err_cnt; rxq.delete();
  endtask

  task automatic send_frame(input logic [15:0] id, input logic [15:0] len, input logic [7:0] t,
                            input bit hbad, input bit pbad, input int gap_at, input int gap_n);
    logic [7:0] b [$];
    b = {8'h01, id[15:8], id[7:0], len[15:8], len[7:0], t, hsum(id, len, t) ^ (hbad ? 8'h24 : 8'h00)};
    if (!hbad && len <= MAXL && len != 0) begin
      for (int i = 0; i < len; i++) b.push_back(pl[i]);
      b.push_back(psum(len) ^ (pbad ? 8'h81 : 8'h00));
    end
    for (int i = 0; i < b.size(); i++) begin
      rx_put(b[i]);
      if (i == gap_at) idle(gap_n);
    end
  endtask

  task automatic check_rx(input string tag, input logic [15:0] id, input logic [15:0] len,
                          input logic [7:0] t, input bit exp_ok);
    bit same;
    idle(2);
    if (exp_ok) begin
      check(ok_cnt - ok0 == 1 && err_cnt == err0, {tag, " ok pulse"}, ok_cnt - ok0, 1);
      check(frm_id == id && frm_len == len && frm_type == t, {tag, " fields R2"},
            {frm_id, frm_len, frm_type}, {id, len, t});
      same = (rxq.size() == int'(len));
      for (int i = 0; i < rxq.size() && same; i++) same = (rxq[i] == pl[i]);
      check(same, {tag, " payload R4"}, rxq.size(), len);
    end else begin
      check(err_cnt - err0 == 1 && ok_cnt == ok0, {tag, " err pulse"}, err_cnt - err0, 1);
    end
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
  endtask

  task automatic tx_frame(input string tag, input logic [7:0] t, input logic [15:0] len,
                          input bit reply, input logic [15:0] rid);
    logic [15:0] eid;
    logic [7:0] e [$];
    int n, guard;
    bit same;
    eid = reply ? rid : {PEER, seq_m};
    if (!reply) seq_m++;
    e = {8'h01, eid[15:8], eid[7:0], len[15:8], len[7:0], t, hsum(eid, len, t)};
    for (int i = 0; i < len; i++) e.push_back(pl[i]);
    if (len != 0) e.push_back(psum(len));
    txq.delete();
    req_valid = 1'b1; req_type = t; req_len = len; req_reply = reply; req_id = rid;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(tx_id == eid, {tag, " id R9/R10"}, tx_id, eid);
    for (int i = 0; i < len; i++) begin
      txp_valid = 1'b1; txp_data = pl[i];
      do @(negedge clk); while (!txp_ready);
      @(posedge clk); #1;
      txp_valid = 1'b0;
    end
    n = e.size();
    guard = 0;
    while (txq.size() < n && guard < 300) begin idle(1); guard++; end
    idle(3);
    same = (txq.size() == n);
    for (int i = 0; i < n && same; i++) same = (txq[i] == e[i]);
    check(same, {tag, " bytes R8"}, txq.size(), n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    check(!frm_ok && !frm_err && rx_ready && req_ready && !out_valid, "reset R2",
          {frm_ok, frm_err, rx_ready, req_ready, out_valid}, 5'b00110);

    // directed receive
    mark(); fill(3); send_frame(16'h1234, 16'd3, 8'h10, 0, 0, -1, 0);
    check_rx("R5 basic", 16'h1234, 16'd3, 8'h10, 1);
    mark(); send_frame(16'h8001, 16'd0, 8'h00, 0, 0, -1, 0);
    check_rx("R5 zero len", 16'h8001, 16'd0, 8'h00, 1);
    mark(); rx_put(8'hFF); rx_put(8'h00); rx_put(8'h7E); fill(2);
    send_frame(16'h0A0B, 16'd2, 8'h21, 0, 0, -1, 0);
    check_rx("R1 junk", 16'h0A0B, 16'd2, 8'h21, 1);
    mark(); send_frame(16'h0102, 16'd4, 8'h05, 1, 0, -1, 0);
    check_rx("R3 bad hdr", 16'h0102, 16'd4, 8'h05, 0);
    mark(); fill(5); send_frame(16'h0304, 16'd5, 8'h06, 0, 1, -1, 0);
    check_rx("R5 bad pay", 16'h0304, 16'd5, 8'h06, 0);
    mark(); send_frame(16'h0506, 16'(MAXL + 1), 8'h07, 0, 0, -1, 0);
    check_rx("R6 too long", 16'h0506, 16'(MAXL + 1), 8'h07, 0);
    mark(); fill(MAXL); send_frame(16'h0708, 16'(MAXL), 8'h08, 0, 0, -1, 0);
    check_rx("R6 at max", 16'h0708, 16'(MAXL), 8'h08, 1);

    // gap timeout
    mark(); rx_put(8'h01); rx_put(8'h55); rx_put(8'h66); idle(6); fill(2);
    send_frame(16'h2222, 16'd2, 8'h11, 0, 0, -1, 0);
    check_rx("R7 gap abort", 16'h2222, 16'd2, 8'h11, 1);
    mark(); fill(4); send_frame(16'h3333, 16'd4, 8'h12, 0, 0, 3, 5);
    check_rx("R7 gap tolerated", 16'h3333, 16'd4, 8'h12, 1);
    gap_limit = 16'd0;
    mark(); send_frame(16'h4444, 16'd4, 8'h13, 0, 0, 8, 60);
    check_rx("R7 timeout off", 16'h4444, 16'd4, 8'h13, 1);
    gap_limit = 16'd5;

    // random receive with back-pressure
    rnd_bp = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [15:0] id, len;
      logic [7:0] t;
      int sel;
      id = 16'($urandom); t = 8'($urandom); len = 16'($urandom % (MAXL + 1));
      sel = $urandom % 6;
      fill(len);
      mark();
      if (sel == 0) begin
        send_frame(id, len, t, 1, 0, -1, 0);
        check_rx("R3 rnd", id, len, t, 0);
      end else if (sel == 1 && len != 0) begin
        send_frame(id, len, t, 0, 1, -1, 0);
        check_rx("R5 rnd", id, len, t, 0);
      end else begin
        send_frame(id, len, t, 0, 0, -1, 0);
        check_rx("R4 rnd", id, len, t, 1);
      end
    end
    rnd_bp = 1'b0;

    // transmit
    fill(4); tx_frame("R9 new", 8'h10, 16'd4, 0, 16'h0);
    tx_frame("R8 zero len", 8'h00, 16'd0, 0, 16'h0);
    fill(3); tx_frame("R10 reply", 8'h11, 16'd3, 1, 16'h0ABC);
    tx_frame("R9 after reply", 8'h12, 16'd0, 0, 16'h0);
    rnd_bp = 1'b1;
    for (int k = 0; k < 30; k++) begin
      logic [15:0] len;
      bit rep;
      len = 16'($urandom % 20);
      rep = ($urandom % 3 == 0);
      fill(len);
      tx_frame(rep ? "R10 rnd" : "R9 rnd", 8'($urandom), len, rep, 16'($urandom));
    end
    rnd_bp = 1'b0;
    idle(2);
    check(ok_cnt >= 0 && !frm_ok && !frm_err, "R11 quiet end", {frm_ok, frm_err}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule